// File: doc/BRIEF.md
# UART Interrupt Source Ranker

This block gathers every interrupt condition of a single UART channel and turns them into one request line and a 4-bit identification code that the host reads to find the cause of the interrupt. There are five sources. Each has a fixed rank and its own code, and each is cleared by its own host access, so a service routine can read the code, do the matching access and read again.

Error and modem-change conditions come in as event bits and are held until the host reads the matching status register. The receive-level and transmit-empty conditions follow their status flags. A receive idle timer watches a non-empty receive FIFO. It raises a timeout when the FIFO has had no pushes and no pops for a set number of character times, and one character time is given as a count of baud ticks.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted and `rx_trig` is low, `iid` is 4'b0001 and `irq` is 0.
- R2: Among enabled pending sources, `iid` reports the one with the highest rank. The ranks and codes, highest first, are: line error 4'b0110, receive timeout 4'b1100, receive data 4'b0100, transmit empty 4'b0010, modem change 4'b0000. With nothing pending and enabled, `iid` is 4'b0001.
- R3: Any set bit of `lsr_evt` makes the line-error source pending from the next cycle. It stays pending until a cycle with `lsr_rd` high. An event in the same cycle as `lsr_rd` leaves the source pending.
- R4: The receive-data source is pending exactly while `rx_trig` is high. Nothing is latched.
- R5: The timeout source becomes pending after CHAR_TIMES×`char_ticks` cycles that have `baud_tick` high, with `rx_nonempty` high and no `rx_push` or `rx_pop` (`char_ticks` ≥ 1). A push or pop restarts the count. A pop clears the pending timeout. It is never reported while `rx_nonempty` is low, and one cycle of empty FIFO clears it.
- R6: A rising edge of `thr_empty` makes the transmit-empty source pending. It is cleared by `thr_wr`, by `thr_empty` going low, or by `iir_rd` in a cycle where `iid` shows 4'b0010. An `iir_rd` while another code is shown leaves it pending.
- R7: Any set bit of `msr_delta` makes the modem source pending until a cycle with `msr_rd` high.
- R8: Enables are mapped as follows: `ier[0]` covers receive data and timeout, `ier[1]` transmit empty, `ier[2]` line error and `ier[3]` modem. A disabled source is not reported, but its pending state is kept and shows as soon as it is enabled.
- R9: `irq` is high exactly when some enabled source is pending, which is exactly when `iid` is not 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier | input | 4 | Source enables (see R8) |
| lsr_evt | input | ERR_W | Overrun, parity, framing, break events |
| lsr_rd | input | 1 | Host reads line status |
| rx_trig | input | 1 | Receive FIFO at or above its trigger level |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_push | input | 1 | Character written into receive FIFO |
| rx_pop | input | 1 | Host reads receive buffer (pop) |
| baud_tick | input | 1 | Baud-rate tick strobe |
| char_ticks | input | TICK_W | Baud ticks per character time |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Host writes transmit holding register |
| iir_rd | input | 1 | Host reads the identification code |
| msr_delta | input | DELTA_W | Modem line change events |
| msr_rd | input | 1 | Host reads modem status |
| iid | output | 4 | Identification code of top source |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 32 combinations of pending sources against all 16 enable patterns. A design with a swapped rank or a wrong code reports the wrong source for some pattern, and one with a misrouted enable either lets a masked source through or hides an enabled one. The timeout is checked one tick before and exactly on its limit, and again after a push has restarted it. An off-by-one counter fires early or late, and a counter that ignores pushes fires too soon. Transmit-empty is read while a line error outranks it, so a design that clears on any code read loses the source. A same-cycle error event and line-status read checks that set wins over clear, and a source is raised while masked to check that its pending state survives.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int NSRC = 5;

   typedef enum logic [3:0] {
      IID_MODEM   = 4'b0000,
      IID_NONE    = 4'b0001,
      IID_THRE    = 4'b0010,
      IID_RXDATA  = 4'b0100,
      IID_LINE    = 4'b0110,
      IID_TIMEOUT = 4'b1100
   } iid_e;

   // rank 0 is the highest priority
   function automatic logic [3:0] rank_code(input int rank);
      case (rank)
         0:       rank_code = IID_LINE;
         1:       rank_code = IID_TIMEOUT;
         2:       rank_code = IID_RXDATA;
         3:       rank_code = IID_THRE;
         default: rank_code = IID_MODEM;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
   parameter int W        = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr,
   output logic         pend
);

   logic any_evt;
   logic pend_d;

   assign any_evt = |evt;

   generate
      if (SET_WINS) begin : g_set_wins
         assign pend_d = (pend & ~clr) | any_evt;
      end else begin : g_clr_wins
         assign pend_d = clr ? 1'b0 : (pend | any_evt);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= pend_d;
   end

endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
   parameter int TICK_W     = 8,
   parameter int CHAR_TIMES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_nonempty,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic              baud_tick,
   input  logic [TICK_W-1:0] char_ticks,
   output logic              pend
);

   localparam int CNT_W = TICK_W + $clog2(CHAR_TIMES + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             idle;

   assign limit = CNT_W'(char_ticks) * CNT_W'(CHAR_TIMES);
   assign idle  = rx_nonempty & ~rx_push & ~rx_pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else if (!idle) begin
         cnt <= '0;
         if (rx_pop || !rx_nonempty) pend <= 1'b0;
      end else if (baud_tick && !pend) begin
         if (cnt == limit - 1'b1) begin
            pend <= 1'b1;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
   input  logic clk,
   input  logic rst_n,
   input  logic thr_empty,
   input  logic thr_wr,
   input  logic id_rd_clr,
   output logic pend
);

   logic empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         pend    <= 1'b0;
      end else begin
         empty_q <= thr_empty;
         if (thr_wr || id_rd_clr || !thr_empty) pend <= 1'b0;
         else if (thr_empty && !empty_q)       pend <= 1'b1;
      end
   end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic [N-1:0] req,
   output logic [3:0]   code,
   output logic         any
);

   logic [N:0] seen;
   logic [3:0] part [N+1];

   assign seen[0] = 1'b0;
   assign part[0] = IID_NONE;

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_rank
         assign seen[i+1] = seen[i] | req[i];
         assign part[i+1] = (req[i] && !seen[i]) ? rank_code(i) : part[i];
      end
   endgenerate

   assign code = part[N];
   assign any  = seen[N];

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int ERR_W      = 4,
   parameter int DELTA_W    = 4,
   parameter int TICK_W     = 8,
   parameter int CHAR_TIMES = 4,
   parameter bit SET_WINS   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         ier,
   input  logic [ERR_W-1:0]   lsr_evt,
   input  logic               lsr_rd,
   input  logic               rx_trig,
   input  logic               rx_nonempty,
   input  logic               rx_push,
   input  logic               rx_pop,
   input  logic               baud_tick,
   input  logic [TICK_W-1:0]  char_ticks,
   input  logic               thr_empty,
   input  logic               thr_wr,
   input  logic               iir_rd,
   input  logic [DELTA_W-1:0] msr_delta,
   input  logic               msr_rd,
   output logic [3:0]         iid,
   output logic               irq
);

   generate
      if (ERR_W < 1 || DELTA_W < 1 || TICK_W < 1 || CHAR_TIMES < 1) begin : g_bad_cfg
         $fatal(1, "uart_irq_ident: widths and CHAR_TIMES must be at least 1");
      end
   endgenerate

   logic            line_pend;
   logic            modem_pend;
   logic            to_pend;
   logic            thre_pend;
   logic [NSRC-1:0] req;
   logic [3:0]      code;
   logic            any;

   uart_irq_sticky #(.W(ERR_W), .SET_WINS(SET_WINS)) u_line (
      .clk(clk), .rst_n(rst_n), .evt(lsr_evt), .clr(lsr_rd), .pend(line_pend)
   );

   uart_irq_sticky #(.W(DELTA_W), .SET_WINS(SET_WINS)) u_modem (
      .clk(clk), .rst_n(rst_n), .evt(msr_delta), .clr(msr_rd), .pend(modem_pend)
   );

   uart_irq_timeout #(.TICK_W(TICK_W), .CHAR_TIMES(CHAR_TIMES)) u_timeout (
      .clk(clk), .rst_n(rst_n), .rx_nonempty(rx_nonempty), .rx_push(rx_push),
      .rx_pop(rx_pop), .baud_tick(baud_tick), .char_ticks(char_ticks), .pend(to_pend)
   );

   uart_irq_thre u_thre (
      .clk(clk), .rst_n(rst_n), .thr_empty(thr_empty), .thr_wr(thr_wr),
      .id_rd_clr(iir_rd && (code == IID_THRE)), .pend(thre_pend)
   );

   // index = rank, 0 highest
   assign req[0] = line_pend & ier[2];
   assign req[1] = to_pend & rx_nonempty & ier[0];
   assign req[2] = rx_trig & ier[0];
   assign req[3] = thre_pend & thr_empty & ier[1];
   assign req[4] = modem_pend & ier[3];

   uart_irq_prio #(.N(NSRC)) u_prio (
      .req(req), .code(code), .any(any)
   );

   assign iid = code;
   assign irq = any;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] ier,
   input logic       lsr_rd,
   input logic       rx_trig,
   input logic       rx_nonempty,
   input logic       iir_rd,
   input logic       msr_rd,
   input logic       line_pend,
   input logic [3:0] iid,
   input logic       irq
);

   assert_reset_idle_R1: assert property (@(posedge clk)
      (!rst_n && !rx_trig) |-> (iid == 4'b0001 && !irq));

   assert_line_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pend && ier[2]) |-> (iid == 4'b0110));

   assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pend && !lsr_rd) |=> line_pend);

   assert_rxdata_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (iid == 4'b0100) |-> (rx_trig && ier[0]));

   assert_timeout_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (iid == 4'b1100) |-> (rx_nonempty && ier[0]));

   assert_thre_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (iid == 4'b0010 && iir_rd) |=> (iid != 4'b0010));

   assert_modem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (iid == 4'b0000 && irq && !msr_rd) |=> (irq || !ier[3]));

   assert_enable_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && iid == 4'b0000) |-> ier[3]);

   assert_irq_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (iid != 4'b0001));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ier(ier), .lsr_rd(lsr_rd), .rx_trig(rx_trig),
   .rx_nonempty(rx_nonempty), .iir_rd(iir_rd), .msr_rd(msr_rd),
   .line_pend(line_pend), .iid(iid), .irq(irq)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] ier;
   logic [3:0] lsr_evt;
   logic       lsr_rd, rx_trig, rx_nonempty, rx_push, rx_pop, baud_tick;
   logic [7:0] char_ticks;
   logic       thr_empty, thr_wr, iir_rd;
   logic [3:0] msr_delta;
   logic       msr_rd;
   logic [3:0] iid;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   uart_irq_ident u_uart_irq_ident (
      .clk(clk), .rst_n(rst_n), .ier(ier), .lsr_evt(lsr_evt), .lsr_rd(lsr_rd),
      .rx_trig(rx_trig), .rx_nonempty(rx_nonempty), .rx_push(rx_push), .rx_pop(rx_pop),
      .baud_tick(baud_tick), .char_ticks(char_ticks), .thr_empty(thr_empty),
      .thr_wr(thr_wr), .iir_rd(iir_rd), .msr_delta(msr_delta), .msr_rd(msr_rd),
      .iid(iid), .irq(irq)
   );

   localparam logic [3:0] C_LINE = 4'b0110, C_TO = 4'b1100, C_DATA = 4'b0100,
                          C_THRE = 4'b0010, C_MODEM = 4'b0000, C_NONE = 4'b0001;

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s iid actual %b expected %b", req, got, exp);
      end
   endtask

   task automatic chk_irq(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s irq actual %b expected %b", req, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_inputs();
      lsr_evt = '0; lsr_rd = 0; rx_trig = 0; rx_nonempty = 0; rx_push = 0;
      rx_pop = 0; baud_tick = 0; char_ticks = 8'd1; thr_empty = 0; thr_wr = 0;
      iir_rd = 0; msr_delta = '0; msr_rd = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle_inputs();
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [3:0] codes [5];
      codes[0] = C_LINE; codes[1] = C_TO; codes[2] = C_DATA;
      codes[3] = C_THRE; codes[4] = C_MODEM;

      // R1 reset state
      rst_n = 1'b0;
      ier   = 4'hF;
      idle_inputs();
      cyc(2);
      chk("R1", iid, C_NONE);
      chk_irq("R1", irq, 1'b0);
      rst_n = 1'b1;
      cyc(1);

      // R2 R8 R9 sweep: every pending set against every enable pattern
      for (int m = 0; m < 32; m++) begin
         ier = 4'h0;
         do_reset();
         rx_nonempty = 1'b1;
         char_ticks  = 8'd1;
         lsr_evt     = m[0] ? (4'b0001 << (m % 4)) : 4'b0000;
         baud_tick   = m[1];
         rx_trig     = m[2];
         thr_empty   = m[3];
         msr_delta   = m[4] ? (4'b1000 >> (m % 4)) : 4'b0000;
         cyc(1);
         lsr_evt   = '0;
         msr_delta = '0;
         cyc(3);
         baud_tick = 1'b0;
         cyc(1);
         for (int e = 0; e < 16; e++) begin
            logic [4:0] en;
            logic [4:0] act;
            logic [3:0] exp;
            ier = e[3:0];
            #2;
            en  = {ier[3], ier[1], ier[0], ier[0], ier[2]};
            act = m[4:0] & en;
            exp = C_NONE;
            for (int i = 4; i >= 0; i--) if (act[i]) exp = codes[i];
            chk("R2/R8", iid, exp);
            chk_irq("R9", irq, act != 5'b0);
            @(negedge clk);
         end
      end

      // R5 timeout timing
      ier = 4'hF;
      do_reset();
      char_ticks  = 8'd3;
      rx_nonempty = 1'b1;
      baud_tick   = 1'b1;
      cyc(11);
      chk("R5 one tick short", iid, C_NONE);
      cyc(1);
      chk("R5 at limit", iid, C_TO);
      baud_tick = 1'b0;
      rx_pop    = 1'b1;
      cyc(1);
      rx_pop = 1'b0;
      chk("R5 pop clears", iid, C_NONE);
      baud_tick = 1'b1;
      cyc(10);
      baud_tick = 1'b0;
      rx_push   = 1'b1;
      cyc(1);
      rx_push   = 1'b0;
      baud_tick = 1'b1;
      cyc(11);
      chk("R5 push restarts", iid, C_NONE);
      cyc(1);
      chk("R5 after restart", iid, C_TO);
      baud_tick   = 1'b0;
      rx_nonempty = 1'b0;
      #2;
      chk("R5 empty hides", iid, C_NONE);
      cyc(1);
      rx_nonempty = 1'b1;
      cyc(1);
      chk("R5 empty clears", iid, C_NONE);
      rx_nonempty = 1'b0;

      // R6 transmit-empty clearing
      thr_empty = 1'b1;
      cyc(1);
      chk("R6 rise", iid, C_THRE);
      iir_rd = 1'b1;
      cyc(1);
      iir_rd = 1'b0;
      chk("R6 id read clears", iid, C_NONE);
      thr_empty = 1'b0;
      cyc(1);
      thr_empty = 1'b1;
      cyc(1);
      lsr_evt = 4'b1000;
      cyc(1);
      lsr_evt = '0;
      chk("R3 line outranks", iid, C_LINE);
      iir_rd = 1'b1;
      cyc(1);
      iir_rd = 1'b0;
      chk("R3 line kept on id read", iid, C_LINE);
      lsr_rd = 1'b1;
      cyc(1);
      lsr_rd = 1'b0;
      chk("R6 kept under line", iid, C_THRE);
      thr_wr = 1'b1;
      cyc(1);
      thr_wr = 1'b0;
      chk("R6 write clears", iid, C_NONE);

      // R3 set wins over clear
      lsr_evt = 4'b0001;
      lsr_rd  = 1'b1;
      cyc(1);
      lsr_evt = '0;
      lsr_rd  = 1'b0;
      chk("R3 set wins", iid, C_LINE);
      cyc(3);
      chk("R3 hold", iid, C_LINE);
      lsr_rd = 1'b1;
      cyc(1);
      lsr_rd = 1'b0;
      chk("R3 read clears", iid, C_NONE);

      // R7 modem change
      msr_delta = 4'b0001;
      cyc(1);
      msr_delta = '0;
      chk("R7 set", iid, C_MODEM);
      chk_irq("R7 irq", irq, 1'b1);
      msr_rd = 1'b1;
      cyc(1);
      msr_rd = 1'b0;
      chk("R7 read clears", iid, C_NONE);
      chk_irq("R7 irq low", irq, 1'b0);

      // R4 receive data follows level
      rx_trig = 1'b1;
      #2;
      chk("R4 level high", iid, C_DATA);
      cyc(1);
      rx_trig = 1'b0;
      #2;
      chk("R4 level low", iid, C_NONE);
      cyc(1);

      // R8 masked source retained
      ier       = 4'h0;
      msr_delta = 4'b0100;
      cyc(1);
      msr_delta = '0;
      cyc(2);
      chk("R8 masked", iid, C_NONE);
      chk_irq("R8 masked irq", irq, 1'b0);
      ier = 4'b1000;
      #2;
      chk("R8 revealed", iid, C_MODEM);
      chk_irq("R8 revealed irq", irq, 1'b1);
      cyc(1);

      summary();
   end

endmodule